// File: doc/BRIEF.md
# Receive Buffer Chain Writer

This block stores one received frame into a linked list of receive buffer descriptors held in a memory organised as 16-bit words. When a frame is offered, it follows a pointer in the control block to the current frame descriptor. It follows that to the first buffer descriptor and then walks the chain buffer by buffer. Into each buffer it writes the frame bytes, followed by the four CRC bytes. It records the byte count and flags in each buffer descriptor. It then hands the unused remainder of the buffer chain to the next frame descriptor, writes the completion status, and raises the frame-received and interrupt pulses.

Frame bytes arrive as a stream with a valid/ready handshake. The frame length, a broadcast/multicast flag and the 32-bit CRC are supplied together with the start pulse. Address filtering and CRC calculation are done outside the block. Memory traffic uses one synchronous port: the address, read enable, write enable, two byte enables and write data are driven combinationally from registered state. Read data returns one cycle after the read.

Top module: `rx_chain_writer`

## Requirements
- R1: On an accepted frame, the frame descriptor pointer is read from control block offset 8. The first buffer descriptor pointer is read from frame descriptor offset 8, and the next frame descriptor pointer from frame descriptor offset 4. Every pointer is two halfwords: the lower address holds bits 15:0 and the address two higher holds bits 31:16.
- R2: In a buffer descriptor, offset 12 is the size word, with the capacity in bits 13:0 and the chain-end flag in bit 15. Offset 8 holds the buffer byte address (even), and offset 4 holds the next buffer descriptor.
- R3: The bytes stored are the frame bytes in arrival order, followed by CRC bits 31:24, 23:16, 15:8 and 7:0. That is frame length plus 4 bytes in total, and it continues across buffer boundaries, so the CRC may be split between two buffers.
- R4: The count for each buffer is the smaller of its capacity and the bytes still to store. A buffer with capacity 0 receives no data bytes and the walk moves on to the next buffer.
- R5: The count is written to buffer descriptor offset 0 in bits 13:0, with bit 14 (filled) always set. Bit 15 is set only on the buffer where the last byte was stored.
- R6: The walk ends after a buffer whose size word has bit 15 set. If bytes remain at that point, no buffer gets bit 15 in its count word, the status OK bit stays clear, and the remaining frame bytes are not taken from the stream.
- R7: The next-descriptor pointer of the last buffer used is written to offsets 8 (bits 15:0) and 10 (bits 31:16) of the next frame descriptor.
- R8: The frame descriptor word at offset 0 is written last. It carries bit 15 set, bit 13 set if the whole frame was stored, and bit 0 equal to the broadcast/multicast flag. All other bits are zero.
- R9: In the cycle after the status write, `fr_cause` and `irq` pulse for one cycle. If bit 14 of the frame descriptor command word (offset 2) was set, `rnr_cause` pulses in that same cycle and the receiver becomes suspended.
- R10: The receiver comes out of reset suspended, and `ru_start` makes it ready. A start while suspended or while `link_up` is low is refused: `frm_refused` pulses in the next cycle, and no memory read or write takes place.
- R11: `busy` rises in the cycle after an accepted start and falls in the cycle after the status write. No memory access happens while it is low.
- R12: Memory bytes are big-endian within a word. A byte at an even address is on `mem_wdata[15:8]` with `mem_be[1]`, and a byte at an odd address is on bits 7:0 with `mem_be[0]`. Descriptor words are written with both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ru_start | input | 1 | Make the receiver ready |
| link_up | input | 1 | Link status; frames are refused while low |
| scb_base | input | AW | Byte address of the control block |
| frm_start | input | 1 | Offer a frame (one-cycle pulse) |
| frm_len | input | LW | Frame length in bytes, CRC excluded |
| frm_bcast | input | 1 | Frame is broadcast or multicast |
| frm_crc | input | 32 | CRC to append, most significant byte first |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Frame byte taken |
| mem_addr | output | AW | Byte address of the access (bit 0 picks the lane for byte writes) |
| mem_rd | output | 1 | Read enable |
| mem_we | output | 1 | Write enable |
| mem_be | output | 2 | Byte enables, bit 1 = even byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Frame in progress |
| frm_refused | output | 1 | Start refused (pulse) |
| ru_suspended | output | 1 | Receiver suspended |
| fr_cause | output | 1 | Frame-received cause (pulse) |
| rnr_cause | output | 1 | Receiver-left-ready cause (pulse) |
| irq | output | 1 | Interrupt pulse |

## Verification
Results fall due at three different times. `frm_refused` and the rising edge of `busy` appear one edge after the start pulse, so they are sampled at the next falling edge. The memory image is only meaningful once `busy` falls, and `fr_cause`, `irq` and `rnr_cause` are valid in that same cycle, so the bench samples them at the first falling edge where `busy` is low. Every count word, data byte, link pointer and status word is read back only after that point. Any write made while `busy` is low is counted as it happens and compared against zero at the end.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  localparam int CW = 14;
  localparam int OFS_FDP  = 8;
  localparam int OFS_CMD  = 2;
  localparam int OFS_RBD  = 8;
  localparam int OFS_NXT  = 4;
  localparam int OFS_BSZ  = 12;
  localparam int OFS_BADR = 8;
  localparam int OFS_LINK = 8;
  typedef enum logic [3:0] {
    S_IDLE, S_FDP, S_CMD, S_RBD, S_NXT, S_BSZ, S_BADR, S_BNXT,
    S_DATA, S_CNT, S_LNK, S_STAT
  } rbw_state_e;
endpackage

// File: rtl/rbw_stream.sv
module rbw_stream #(
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic [31:0]   crc,
  input  logic          want,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          byte_avail,
  output logic [7:0]    byte_val,
  output logic [LW:0]   rem
);
  logic [LW-1:0] frm_left;
  logic [31:0]   crc_q;
  logic          take;
  logic [1:0]    crc_sel;

  assign crc_sel    = rem[1:0] - 2'd1;
  assign byte_avail = (frm_left != '0) ? in_valid : (rem != '0);
  assign byte_val   = (frm_left != '0) ? in_data : 8'(crc_q >> {crc_sel, 3'b000});
  assign take       = want && byte_avail;
  assign in_ready   = want && (frm_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_left <= '0;
      rem      <= '0;
      crc_q    <= '0;
    end else if (load) begin
      frm_left <= len;
      rem      <= (LW+1)'(len) + (LW+1)'(4);
      crc_q    <= crc;
    end else if (take) begin
      rem <= rem - 1'b1;
      if (frm_left != '0) frm_left <= frm_left - 1'b1;
    end
  end

  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(take) && !$past(load)) |-> (rem == $past(rem) - 1'b1)); // R3
endmodule

// File: rtl/rbw_cause.sv
module rbw_cause (
  input  logic clk,
  input  logic rst,
  input  logic frm_start,
  input  logic link_up,
  input  logic ru_start,
  input  logic busy,
  input  logic fin,
  input  logic susp_req,
  output logic accept,
  output logic refused,
  output logic suspended,
  output logic fr,
  output logic rnr,
  output logic irq
);
  assign accept = frm_start && !busy && !suspended && link_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      suspended <= 1'b1;
      refused   <= 1'b0;
      fr        <= 1'b0;
      rnr       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      refused <= frm_start && !busy && (suspended || !link_up);
      fr      <= fin;
      irq     <= fin;
      rnr     <= fin && susp_req;
      if (fin && susp_req) suspended <= 1'b1;
      else if (ru_start)   suspended <= 1'b0;
    end
  end

  AST_RNR_SUSP: assert property (@(posedge clk) disable iff (rst)
    rnr |-> suspended); // R9
  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!suspended && link_up)); // R10
endmodule

// File: rtl/rbw_ctrl.sv
module rbw_ctrl
  import rbw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          bcast_in,
  input  logic [AW-1:0] scb_base,
  input  logic [15:0]   mem_rdata,
  input  logic          byte_avail,
  input  logic [7:0]    byte_val,
  input  logic [LW:0]   rem,
  output logic          want,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  output logic          busy,
  output logic          fin,
  output logic          susp_req
);
  rbw_state_e    st;
  logic [1:0]    ph;
  logic [15:0]   lo_q;
  logic [AW-1:0] fd, nfd, rbd, rbd_nxt, rba;
  logic [CW-1:0] cnt, k;
  logic          el, bcast, trunc;
  logic [31:0]   p32, nxt32;
  logic [AW-1:0] ptr, hoff;
  logic          pair_done, stored_all;

  assign p32        = {mem_rdata, lo_q};
  assign ptr        = p32[AW-1:0];
  assign nxt32      = 32'(rbd_nxt);
  assign pair_done  = (ph == 2'd2);
  assign hoff       = ph[0] ? AW'(2) : AW'(0);
  assign stored_all = (rem == '0);
  assign fin        = (st == S_STAT);

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 2'b11;
    mem_wdata = '0;
    want      = 1'b0;
    case (st)
      S_FDP:  begin mem_addr = scb_base + AW'(OFS_FDP) + hoff; mem_rd = !ph[1]; end
      S_CMD:  begin mem_addr = fd + AW'(OFS_CMD);  mem_rd = !ph[0]; end
      S_RBD:  begin mem_addr = fd + AW'(OFS_RBD) + hoff;  mem_rd = !ph[1]; end
      S_NXT:  begin mem_addr = fd + AW'(OFS_NXT) + hoff;  mem_rd = !ph[1]; end
      S_BSZ:  begin mem_addr = rbd + AW'(OFS_BSZ); mem_rd = !ph[0]; end
      S_BADR: begin mem_addr = rbd + AW'(OFS_BADR) + hoff; mem_rd = !ph[1]; end
      S_BNXT: begin mem_addr = rbd + AW'(OFS_NXT) + hoff;  mem_rd = !ph[1]; end
      S_DATA: begin
        want      = 1'b1;
        mem_addr  = rba + AW'(k);
        mem_we    = byte_avail;
        mem_be    = mem_addr[0] ? 2'b01 : 2'b10;
        mem_wdata = {byte_val, byte_val};
      end
      S_CNT: begin
        mem_addr  = rbd;
        mem_we    = 1'b1;
        mem_wdata = {stored_all, 1'b1, cnt};
      end
      S_LNK: begin
        mem_addr  = nfd + AW'(OFS_LINK) + hoff;
        mem_we    = 1'b1;
        mem_wdata = ph[0] ? nxt32[31:16] : nxt32[15:0];
      end
      S_STAT: begin
        mem_addr  = fd;
        mem_we    = 1'b1;
        mem_wdata = {1'b1, 1'b0, !trunc, 12'd0, bcast};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; lo_q <= '0; busy <= 1'b0;
      fd <= '0; nfd <= '0; rbd <= '0; rbd_nxt <= '0; rba <= '0;
      cnt <= '0; k <= '0; el <= 1'b0; bcast <= 1'b0; trunc <= 1'b0;
      susp_req <= 1'b0;
    end else begin
      if (ph == 2'd1) lo_q <= mem_rdata;
      case (st)
        S_IDLE: if (accept) begin
          st <= S_FDP; ph <= '0; busy <= 1'b1; bcast <= bcast_in; trunc <= 1'b0;
        end
        S_FDP: begin
          ph <= pair_done ? 2'd0 : ph + 2'd1;
          if (pair_done) begin fd <= ptr; st <= S_CMD; end
        end
        S_CMD: begin
          ph <= ph[0] ? 2'd0 : 2'd1;
          if (ph[0]) begin susp_req <= mem_rdata[14]; st <= S_RBD; end
        end
        S_RBD: begin
          ph <= pair_done ? 2'd0 : ph + 2'd1;
          if (pair_done) begin rbd <= ptr; st <= S_NXT; end
        end
        S_NXT: begin
          ph <= pair_done ? 2'd0 : ph + 2'd1;
          if (pair_done) begin nfd <= ptr; st <= S_BSZ; end
        end
        S_BSZ: begin
          ph <= ph[0] ? 2'd0 : 2'd1;
          if (ph[0]) begin
            el  <= mem_rdata[15];
            cnt <= (32'(rem) < 32'(mem_rdata[CW-1:0])) ? CW'(rem) : mem_rdata[CW-1:0];
            st  <= S_BADR;
          end
        end
        S_BADR: begin
          ph <= pair_done ? 2'd0 : ph + 2'd1;
          if (pair_done) begin rba <= ptr; st <= S_BNXT; end
        end
        S_BNXT: begin
          ph <= pair_done ? 2'd0 : ph + 2'd1;
          if (pair_done) begin
            rbd_nxt <= ptr;
            k       <= '0;
            st      <= (cnt == '0) ? S_CNT : S_DATA;
          end
        end
        S_DATA: if (byte_avail) begin
          k <= k + 1'b1;
          if (k == cnt - 1'b1) st <= S_CNT;
        end
        S_CNT: begin
          if (stored_all || el) begin
            trunc <= !stored_all;
            st    <= S_LNK;
            ph    <= '0;
          end else begin
            rbd <= rbd_nxt;
            st  <= S_BSZ;
            ph  <= '0;
          end
        end
        S_LNK: begin
          ph <= ph[0] ? 2'd0 : 2'd1;
          if (ph[0]) st <= S_STAT;
        end
        S_STAT: begin
          st   <= S_IDLE;
          busy <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_we || mem_rd)); // R11
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_we && mem_wdata[15] && (mem_be == 2'b11))); // R8
endmodule

// File: rtl/rx_chain_writer.sv
module rx_chain_writer #(
  parameter int AW = 32,
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ru_start,
  input  logic          link_up,
  input  logic [AW-1:0] scb_base,
  input  logic          frm_start,
  input  logic [LW-1:0] frm_len,
  input  logic          frm_bcast,
  input  logic [31:0]   frm_crc,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          frm_refused,
  output logic          ru_suspended,
  output logic          fr_cause,
  output logic          rnr_cause,
  output logic          irq
);
  logic          accept, want, byte_avail, fin, susp_req;
  logic [7:0]    byte_val;
  logic [LW:0]   rem;

  rbw_cause u_cause (
    .clk(clk), .rst(rst), .frm_start(frm_start), .link_up(link_up),
    .ru_start(ru_start), .busy(busy), .fin(fin), .susp_req(susp_req),
    .accept(accept), .refused(frm_refused), .suspended(ru_suspended),
    .fr(fr_cause), .rnr(rnr_cause), .irq(irq)
  );

  rbw_stream #(.LW(LW)) u_stream (
    .clk(clk), .rst(rst), .load(accept), .len(frm_len), .crc(frm_crc),
    .want(want), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .byte_avail(byte_avail), .byte_val(byte_val), .rem(rem)
  );

  rbw_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept), .bcast_in(frm_bcast),
    .scb_base(scb_base), .mem_rdata(mem_rdata), .byte_avail(byte_avail),
    .byte_val(byte_val), .rem(rem), .want(want), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .busy(busy), .fin(fin), .susp_req(susp_req)
  );
endmodule

// File: tb/rx_chain_writer_bench.sv
module rx_chain_writer_bench;
  localparam int AW = 12;
  localparam int LW = 14;
  localparam int NB = 24;
  localparam int SCB = 'h040, FD = 'h080, NFD = 'h0A0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, ru_start, link_up, frm_start, frm_bcast, in_valid, in_ready;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_we, busy, frm_refused, ru_suspended, fr_cause, rnr_cause, irq;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;
  logic [LW-1:0] frm_len;
  logic [31:0] frm_crc;
  logic [7:0] in_data;

  logic [15:0] mem [0:(1<<(AW-1))-1];
  logic bwe;
  logic [AW-1:0] baddr;
  logic [15:0] bdata;
  int compared = 0, mismatched = 0, stray = 0;
  int src_idx, cur_len, cur_seed;
  logic src_clr;

  rx_chain_writer #(.AW(AW), .LW(LW)) u_rx_chain_writer (
    .clk(clk), .rst(rst), .ru_start(ru_start), .link_up(link_up),
    .scb_base(AW'(SCB)), .frm_start(frm_start), .frm_len(frm_len),
    .frm_bcast(frm_bcast), .frm_crc(frm_crc), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .frm_refused(frm_refused),
    .ru_suspended(ru_suspended), .fr_cause(fr_cause), .rnr_cause(rnr_cause),
    .irq(irq)
  );

  function automatic logic [31:0] crc_of(int seed);
    return 32'hC1D2E3F4 ^ 32'(seed);
  endfunction

  function automatic logic [7:0] sb(int j, int len, int seed);
    if (j < len) return 8'(j * 7 + seed);
    return 8'(crc_of(seed) >> (24 - 8 * (j - len)));
  endfunction

  assign in_valid = (src_idx < cur_len);
  assign in_data  = sb(src_idx, cur_len, cur_seed);

  always_ff @(posedge clk) begin
    if (src_clr) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;
    mem_rdata <= mem[mem_addr[AW-1:1]];
    if (bwe) mem[baddr[AW-1:1]] <= bdata;
    else if (mem_we) begin
      if (mem_be[1]) mem[mem_addr[AW-1:1]][15:8] <= mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr[AW-1:1]][7:0]  <= mem_wdata[7:0];
    end
    if (!rst && !busy && (mem_we || mem_rd)) stray <= stray + 1;
  end

  function automatic int rd16(int a);
    return int'(mem[a >> 1]);
  endfunction
  function automatic int rd8(int a);
    logic [15:0] w;
    w = mem[a >> 1];
    return (a % 2 == 0) ? int'(w[15:8]) : int'(w[7:0]);
  endfunction
  function automatic int rbd_at(int i); return 'h100 + 16 * i; endfunction
  function automatic int buf_at(int i); return 'h400 + 'h40 * i; endfunction

  task automatic chk(string tag, int got, int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bw(int a, int v);
    baddr = AW'(a); bdata = 16'(v); bwe = 1'b1;
    @(negedge clk);
    bwe = 1'b0;
  endtask
  task automatic bw32(int a, int v);
    bw(a, v & 'hFFFF);
    bw(a + 2, (v >> 16) & 'hFFFF);
  endtask

  task automatic start_pulse();
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  int caps [NB];

  task automatic run_case(int len, int cap, int zero_idx, int el_idx, bit bc, bit susp, int seed);
    int rem, cnt, last, wd;
    string tg;
    bw32(SCB + 8, FD);
    bw(FD, 'h1234);
    bw(FD + 2, susp ? 'h4000 : 0);
    bw32(FD + 4, NFD);
    bw32(FD + 8, rbd_at(0));
    bw32(NFD + 8, 0);
    for (int i = 0; i < NB; i++) begin
      caps[i] = (i == zero_idx) ? 0 : cap;
      bw(rbd_at(i), 0);
      bw32(rbd_at(i) + 4, rbd_at(i + 1));
      bw32(rbd_at(i) + 8, buf_at(i));
      bw(rbd_at(i) + 12, caps[i] | ((i == el_idx) ? 'h8000 : 0));
      for (int w = 0; w < (cap + 1) / 2; w++) bw(buf_at(i) + 2 * w, 0);
    end
    src_clr = 1'b1; cur_len = len; cur_seed = seed;
    @(negedge clk);
    src_clr = 1'b0;
    frm_len = LW'(len); frm_bcast = bc; frm_crc = crc_of(seed);
    start_pulse();
    chk("R11 busy after start", int'(busy), 1);
    wd = 0;
    while (busy && wd < 20000) begin @(negedge clk); wd++; end
    if (wd >= 20000) chk("R11 watchdog", 1, 0);
    chk("R9 fr_cause", int'(fr_cause), 1);
    chk("R9 irq", int'(irq), 1);
    chk("R9 rnr_cause", int'(rnr_cause), int'(susp));
    chk("R9 suspended", int'(ru_suspended), int'(susp));
    @(negedge clk);
    chk("R9 pulse width", int'(fr_cause | irq | rnr_cause), 0);
    rem = len + 4; last = 0;
    for (int i = 0; i < NB; i++) begin
      cnt = (caps[i] < rem) ? caps[i] : rem;
      for (int b = 0; b < cnt; b++)
        chk("R3 R12 R2 byte", rd8(buf_at(i) + b), int'(sb(len + 4 - rem + b, len, seed)));
      rem -= cnt;
      tg = (i == zero_idx) ? "R4 zero-capacity count" : "R4 R5 count word";
      chk(tg, rd16(rbd_at(i)), 'h4000 | cnt | ((rem == 0) ? 'h8000 : 0));
      last = i;
      if (rem == 0 || i == el_idx) break;
    end
    if (last + 1 < NB) chk("R6 R5 next buffer untouched", rd16(rbd_at(last + 1)), 0);
    chk("R6 frame bytes left", cur_len - src_idx, (rem > 4) ? rem - 4 : 0);
    chk("R7 link lo", rd16(NFD + 8), rbd_at(last + 1) & 'hFFFF);
    chk("R7 link hi", rd16(NFD + 10), 0);
    chk("R8 R1 status", rd16(FD), ((rem == 0) ? 'hA000 : 'h8000) | int'(bc));
    if (susp) begin
      ru_start = 1'b1; @(negedge clk); ru_start = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; ru_start = 0; link_up = 1; frm_start = 0; frm_bcast = 0;
    frm_len = '0; frm_crc = '0; bwe = 0; baddr = '0; bdata = '0;
    src_clr = 1'b1; cur_len = 0; cur_seed = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0; src_clr = 1'b0;
    @(negedge clk);
    chk("R10 reset suspended", int'(ru_suspended), 1);
    chk("R11 reset busy", int'(busy), 0);
    chk("R9 reset irq", int'(irq | fr_cause | rnr_cause | frm_refused), 0);
    // refused while suspended
    bw(FD, 'h1234);
    frm_len = LW'(4);
    start_pulse();
    chk("R10 refused suspended", int'(frm_refused), 1);
    chk("R10 no busy when refused", int'(busy), 0);
    @(negedge clk);
    chk("R10 status untouched", rd16(FD), 'h1234);
    ru_start = 1'b1; @(negedge clk); ru_start = 1'b0;
    chk("R10 ready after start", int'(ru_suspended), 0);
    // refused with link down
    link_up = 1'b0;
    start_pulse();
    chk("R10 refused link down", int'(frm_refused), 1);
    @(negedge clk);
    chk("R10 still idle", int'(busy), 0);
    link_up = 1'b1;
    // sweep length x capacity
    foreach (caps[i]) caps[i] = 0;
    for (int li = 0; li < 6; li++) begin
      for (int ci = 0; ci < 5; ci++) begin
        int lens [6] = '{1, 2, 3, 6, 9, 14};
        int cps [5] = '{1, 2, 3, 5, 8};
        run_case(lens[li], cps[ci], -1, NB - 1, (li % 2) == 1, 1'b0, li * 5 + ci);
      end
    end
    run_case(5, 4, 1, NB - 1, 1'b0, 1'b0, 40);   // R4 zero capacity
    run_case(9, 3, -1, 1, 1'b0, 1'b0, 41);       // R6 chain ends early
    run_case(7, 6, -1, NB - 1, 1'b1, 1'b1, 42);  // R9 suspend
    chk("R11 no access while idle", stray, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule